// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Unit

This unit sits between a 32-bit register datapath and a byte-addressed data memory organised as 32-bit words. It forms the effective address from a base register value plus a sign-extended 16-bit displacement. It then steers data between the register and the memory word lanes using big-endian lane order: the byte at the lowest address of a word occupies bits [31:24].

For a store, it places the low byte, the low halfword or the whole register value on the matching memory lanes and raises one write enable per lane. For a load, it extracts the addressed byte or halfword from the memory read word. It then widens the value to 32 bits with either sign or zero extension. Halfword and word accesses that do not fall on their natural boundary are flagged and have no effect on memory or on the register.

All results are registered and appear one clock after the request.

Top module: `lsu_be_lane`

## Requirements
- R1: The memory word address output equals bits [31:2] of (base + the 16-bit displacement sign-extended to 32 bits).
- R2: A byte store (size 00) at address offset k = addr[1:0] enables only lane bit 3-k of the 4-bit enable. Enable bit i covers data bits [8i+7:8i]. The low register byte is copied into all four lanes.
- R3: A halfword store (size 01) enables 4'b1100 when addr[1] is 0 and 4'b0011 when addr[1] is 1. The low register halfword is copied into both halves.
- R4: A word store (size 10) enables 4'b1111 and writes the register value unchanged.
- R5: A byte load returns memory bits [31-8k:24-8k]. When the unsigned flag is 1 the value is zero-extended; when it is 0 the value is sign-extended (0xC5 gives 0x000000C5 or 0xFFFFFFC5). A load never raises a write enable.
- R6: A halfword load returns bits [31:16] when addr[1] is 0 and bits [15:0] when addr[1] is 1. The value is extended as in R5.
- R7: A word load returns the memory word unchanged.
- R8: A halfword access with addr[0] = 1, or a word access with addr[1:0] != 0, raises the misaligned output. It forces the enables, the write data and the load data to zero. A byte access is never misaligned.
- R9: Every output reflects the request of the previous clock. With no request, valid, misaligned, enables, write data and load data are zero.
- R10: While reset is asserted, every output is zero.
- R11: Size code 11 behaves exactly as a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| is_store_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | 00 byte, 01 halfword, 10/11 word |
| unsigned_i | input | 1 | Zero-extend loads when 1 |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| store_data_i | input | 32 | Register value to store |
| mem_rdata_i | input | 32 | Memory read word for this request |
| valid_o | output | 1 | Registered result valid |
| mem_word_addr_o | output | 30 | Word address |
| mem_wdata_o | output | 32 | Memory write word |
| mem_be_o | output | 4 | Per-lane write enables, bit 3 = bits [31:24] |
| load_data_o | output | 32 | Extended load value |
| misaligned_o | output | 1 | Alignment fault |

## Verification
Every result passes through exactly one register. A request driven before a rising edge is therefore visible from that edge onward. The bench drives each request at a falling edge and samples all outputs at the next falling edge, one full cycle later. It then drops the request and checks that the following sample returns to the idle values.

// File: rtl/lsu_be_pkg.sv
package lsu_be_pkg;
  localparam int XLEN  = 32;
  localparam int NB    = XLEN / 8;
  localparam int OFF_W = $clog2(NB);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_be_pkg::*;
#(
  parameter int DISP_W = 16
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  acc_size_e         size_i,
  output logic [XLEN-1:0]   addr_o,
  output logic              mis_o
);
  localparam int EXT_W = XLEN - DISP_W;

  always_comb begin
    addr_o = base_i + {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    unique case (size_i)
      SZ_BYTE: mis_o = 1'b0;
      SZ_HALF: mis_o = addr_o[0];
      default: mis_o = |addr_o[OFF_W-1:0];
    endcase
  end

  always_comb begin
    p_byte_never_mis_r8: assert (!(size_i == SZ_BYTE && mis_o));
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_be_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  acc_size_e        size_i,
  input  logic [XLEN-1:0]  data_i,
  output logic [XLEN-1:0]  wdata_o,
  output logic [NB-1:0]    be_o
);
  // lane i holds bits [8i+7:8i], lowest byte address NB-1-i (big endian)
  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LADDR = OFF_W'(NB - 1 - i);
    always_comb begin
      unique case (size_i)
        SZ_BYTE: begin
          be_o[i]          = (off_i == LADDR);
          wdata_o[8*i +: 8] = data_i[7:0];
        end
        SZ_HALF: begin
          be_o[i]          = (off_i[1] == LADDR[1]);
          wdata_o[8*i +: 8] = LADDR[0] ? data_i[7:0] : data_i[15:8];
        end
        default: begin
          be_o[i]          = 1'b1;
          wdata_o[8*i +: 8] = data_i[8*i +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane
  import lsu_be_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  acc_size_e        size_i,
  input  logic             unsigned_i,
  input  logic [XLEN-1:0]  rdata_i,
  output logic [XLEN-1:0]  value_o
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  always_comb begin
    byte_sel = rdata_i[8*(NB-1-int'(off_i)) +: 8];
    half_sel = off_i[1] ? rdata_i[15:0] : rdata_i[31:16];
    unique case (size_i)
      SZ_BYTE: value_o = {{(XLEN-8){~unsigned_i & byte_sel[7]}}, byte_sel};
      SZ_HALF: value_o = {{(XLEN-16){~unsigned_i & half_sel[15]}}, half_sel};
      default: value_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/lsu_be_lane.sv
module lsu_be_lane
  import lsu_be_pkg::*;
#(
  parameter int DISP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              is_store_i,
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   store_data_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic              valid_o,
  output logic [XLEN-3:0]   mem_word_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic [NB-1:0]     mem_be_o,
  output logic [XLEN-1:0]   load_data_o,
  output logic              misaligned_o
);
  acc_size_e       size;
  logic [XLEN-1:0] addr, wdata, ldata;
  logic [NB-1:0]   be;
  logic            mis, st_ok, ld_ok;

  assign size = acc_size_e'(size_i);

  lsu_agen #(.DISP_W(DISP_W)) i_agen (
    .base_i (base_i), .disp_i (disp_i), .size_i (size),
    .addr_o (addr),   .mis_o  (mis)
  );

  lsu_store_lane i_store (
    .off_i (addr[OFF_W-1:0]), .size_i (size), .data_i (store_data_i),
    .wdata_o (wdata), .be_o (be)
  );

  lsu_load_lane i_load (
    .off_i (addr[OFF_W-1:0]), .size_i (size), .unsigned_i (unsigned_i),
    .rdata_i (mem_rdata_i), .value_o (ldata)
  );

  assign st_ok = req_valid_i & is_store_i & ~mis;
  assign ld_ok = req_valid_i & ~is_store_i & ~mis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o         <= 1'b0;
      mem_word_addr_o <= '0;
      mem_wdata_o     <= '0;
      mem_be_o        <= '0;
      load_data_o     <= '0;
      misaligned_o    <= 1'b0;
    end else begin
      valid_o         <= req_valid_i;
      mem_word_addr_o <= req_valid_i ? addr[XLEN-1:2] : '0;
      mem_wdata_o     <= st_ok ? wdata : '0;
      mem_be_o        <= st_ok ? be : '0;
      load_data_o     <= ld_ok ? ldata : '0;
      misaligned_o    <= req_valid_i & mis;
    end
  end

  p_valid_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (mem_be_o == '0 && !misaligned_o && load_data_o == '0));
  p_mis_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misaligned_o |-> (mem_be_o == '0 && load_data_o == '0 && mem_wdata_o == '0));
  p_load_no_be_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !is_store_i) |=> mem_be_o == '0);
  p_be_shape_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mem_be_o) != 3);
  p_word_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_store_i && size_i[1] && !mis) |=> mem_be_o == '1);
endmodule

// File: tb/test_lsu_be_lane.sv
module test_lsu_be_lane;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, is_store_i = 1'b0, unsigned_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [31:0] base_i = '0, store_data_i = '0, mem_rdata_i = '0;
  logic [15:0] disp_i = '0;
  logic        valid_o, misaligned_o;
  logic [29:0] mem_word_addr_o;
  logic [31:0] mem_wdata_o, load_data_o;
  logic [3:0]  mem_be_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_be_lane i_lsu_be_lane (
    .clk_i (clk), .rst_ni (rst_ni), .req_valid_i (req_valid_i),
    .is_store_i (is_store_i), .size_i (size_i), .unsigned_i (unsigned_i),
    .base_i (base_i), .disp_i (disp_i), .store_data_i (store_data_i),
    .mem_rdata_i (mem_rdata_i), .valid_o (valid_o),
    .mem_word_addr_o (mem_word_addr_o), .mem_wdata_o (mem_wdata_o),
    .mem_be_o (mem_be_o), .load_data_o (load_data_o),
    .misaligned_o (misaligned_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check_idle(input string req);
    chk({req, " valid"}, 32'(valid_o), 0);
    chk({req, " be"}, 32'(mem_be_o), 0);
    chk({req, " wdata"}, mem_wdata_o, 0);
    chk({req, " load"}, load_data_o, 0);
    chk({req, " mis"}, 32'(misaligned_o), 0);
  endtask

  task automatic run(input logic st, input logic [1:0] sz, input logic uns,
                     input logic [31:0] b, input logic [15:0] d,
                     input logic [31:0] sd, input logic [31:0] rd);
    logic [31:0] ea, e_wd, e_ld, v;
    logic [3:0]  e_be;
    logic [1:0]  k;
    logic        e_mis;
    string       tag;
    ea = b + {{16{d[15]}}, d};
    k  = ea[1:0];
    e_mis = (sz == 2'b01 && k[0]) || (sz[1] && k != 2'b00);
    case (sz)
      2'b00: begin
        e_be = 4'b1000 >> k; e_wd = sd[7:0] * 32'h0101_0101;
        v = (rd >> (8 * (3 - k))) & 32'hFF;
        e_ld = (!uns && v[7]) ? (v | 32'hFFFF_FF00) : v;
        tag = st ? "R2" : "R5";
      end
      2'b01: begin
        e_be = k[1] ? 4'b0011 : 4'b1100; e_wd = sd[15:0] * 32'h0001_0001;
        v = (rd >> (k[1] ? 0 : 16)) & 32'hFFFF;
        e_ld = (!uns && v[15]) ? (v | 32'hFFFF_0000) : v;
        tag = st ? "R3" : "R6";
      end
      default: begin
        e_be = 4'hF; e_wd = sd; e_ld = rd;
        tag = (sz == 2'b11) ? "R11" : (st ? "R4" : "R7");
      end
    endcase
    if (e_mis) begin
      e_be = '0; e_wd = '0; e_ld = '0; tag = {tag, "/R8"};
    end else if (st) begin
      e_ld = '0;
    end else begin
      e_be = '0; e_wd = '0;
    end
    @(negedge clk);
    req_valid_i = 1'b1; is_store_i = st; size_i = sz; unsigned_i = uns;
    base_i = b; disp_i = d; store_data_i = sd; mem_rdata_i = rd;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R9 valid", 32'(valid_o), 1);
    chk("R1 addr", 32'(mem_word_addr_o), 32'(ea[31:2]));
    chk({tag, " mis"}, 32'(misaligned_o), 32'(e_mis));
    chk({tag, " be"}, 32'(mem_be_o), 32'(e_be));
    chk({tag, " wdata"}, mem_wdata_o, e_wd);
    chk({tag, " load"}, load_data_o, e_ld);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R10 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("R9 idle");
    // R1: displacement 32 from base addresses word index 8
    run(1'b0, 2'b10, 1'b0, 32'h1000_7FF8, 16'd32, 32'h0, 32'h1234_5678);
    chk("R1 disp32", 32'(mem_word_addr_o), 32'(32'h1000_8018 >> 2));
    // R5: 0xC5 byte signed and unsigned
    run(1'b0, 2'b00, 1'b0, 32'h2000_0000, 16'd0, 32'h0, 32'hC500_0000);
    chk("R5 C5 signed", load_data_o, 32'hFFFF_FFC5);
    run(1'b0, 2'b00, 1'b1, 32'h2000_0000, 16'd0, 32'h0, 32'hC500_0000);
    chk("R5 C5 unsigned", load_data_o, 32'h0000_00C5);
    for (int dd = -4; dd < 8; dd++)
      for (int sz = 0; sz < 4; sz++)
        for (int st = 0; st < 2; st++)
          for (int u = 0; u < 2; u++) begin
            run(st[0], sz[1:0], u[0], 32'h1000_7FF8, 16'(dd), 32'hA1B2_C3D4, 32'h8C7E_F081);
            run(st[0], sz[1:0], u[0], 32'h0000_0100, 16'(dd), 32'h5E6F_7788, 32'h7F80_01FE);
          end
    @(negedge clk);
    check_idle("R9 drop");
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 act=hung exp=done");
      summary();
    end
  end
endmodule